// File: doc/BRIEF.md
# SD Card Clock Divider

This block produces the card clock of an SD host controller from its base clock. It also holds the 16-bit clock control word that governs that clock. Software sets a divisor code and turns on the internal clock. It then polls a read-only stable flag, and once the flag is set it turns on the card clock. The divisor is interpreted in one of two ways, chosen by an elaboration parameter:

- **Power-of-two mode** (older hosts): an 8-bit code where only one set bit is meaningful.
- **Even-divisor mode** (newer hosts): a 10-bit code whose two top bits sit in a separate field of the word.

In both modes a code of zero passes the base clock straight through. A nonzero code N divides the base clock by 2N, giving equal high and low phases of N base cycles each.

The divisor is captured only when the internal clock is turned on. The phase counter restarts from zero whenever the internal clock is off. When the card clock enable is dropped, the pulse in progress finishes its full high phase before the output parks low.

Top module: `sdclk_divider_unit`

## Requirements
- R1: After reset the control word reads 0x0000. The fields are:
  - bit 0: internal clock enable.
  - bit 1: stable flag.
  - bit 2: card clock enable.
  - bits 7:6: upper divisor bits.
  - bits 15:8: lower divisor code.
  - bits 5:3: always read 0.
- R2: The stable flag is read-only: a write to bit 1 has no effect. The flag reads 0 whenever bit 0 is 0.
- R3: The stable flag reads 1 exactly SETTLE_CYCLES base-clock rising edges after the edge that captures bit 0 = 1. It reads 0 from the edge that captures bit 0 = 0.
- R4: With a divisor code of 0, the card clock equals the base clock (high during the base clock's high phase) while it is enabled and the internal clock is stable.
- R5: In power-of-two mode, a code N with one set bit gives a card clock of period 2N base cycles, high N and low N. The largest code, 128, gives a ratio of 256.
- R6: In power-of-two mode:
  - a code with several set bits acts as its highest set bit;
  - writes to bits 7:6 are ignored, and those bits read 0.
- R7: In even-divisor mode, N = {bits 7:6, bits 15:8} and the period is 2N base cycles, high N and low N. N = 1023 gives a ratio of 2046.
- R8: The card clock stays low while the card enable is 0, while the internal clock is off, and until the stable flag is set.
- R9: Clearing the card enable while the card clock is high never shortens that high phase: it lasts the full N cycles, and the output then stays low.
- R10: The divisor takes effect only when bit 0 goes from 0 to 1. Divisor writes while the clock runs are stored and read back but do not change the card clock rate until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_clk | input | 1 | Base clock; every register updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Writes wr_data into the control word at the rising edge |
| wr_data | input | 16 | Control word value to write |
| rd_data | output | 16 | Current control word, stable flag included |
| card_clk | output | 1 | Divided, gated clock for the card |

## Verification
The scoreboard measures every high phase and every steady low phase of the card clock in base cycles. A design that is off by one in its terminal count, or that divides by N instead of 2N, fails on the first pulse.

The card enable is dropped while the card clock is high. This catches a gate that cuts the pulse short and leaves a runt.

Three corner cases have their own tests:
- A multi-bit code in power-of-two mode exposes a design that divides by the raw code.
- The largest codes in both modes expose a truncated counter or a lost upper field.
- Rewriting the divisor mid-run exposes a design that picks up the new ratio at once.

The stable flag is sampled on the cycle before and the cycle of its expected rise, which pins the settle count exactly.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Width of the half-period count; covers the 10-bit divisor field.
  localparam int HALF_W = 10;

  // Control word field positions (decoded by software, so fixed).
  localparam int BIT_INT_EN = 0;
  localparam int BIT_STABLE = 1;
  localparam int BIT_CARD_EN = 2;
  localparam int HI_LSB = 6;
  localparam int LO_LSB = 8;

  // Power-of-two code: keep only the most significant set bit.
  function automatic logic [HALF_W-1:0] half_pow2(input logic [7:0] code);
    logic [HALF_W-1:0] r;
    r = '0;
    for (int b = 0; b < 8; b++) begin
      if (code[b]) r = HALF_W'(1) << b;
    end
    return r;
  endfunction

  // Even-divisor code: upper two bits join the lower byte.
  function automatic logic [HALF_W-1:0] half_even(input logic [1:0] up,
                                                  input logic [7:0] lo);
    return {up, lo};
  endfunction

  // Half period in base cycles; zero means pass-through.
  function automatic logic [HALF_W-1:0] decode_half(input bit wide,
                                                    input logic [1:0] up,
                                                    input logic [7:0] lo);
    return wide ? half_even(up, lo) : half_pow2(lo);
  endfunction

endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
  import sdclk_pkg::*;
#(
  parameter bit DIV10_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic              int_en_o,
  output logic              card_en_o,
  output logic [1:0]        div_hi_o,
  output logic [7:0]        div_lo_o,
  output logic [HALF_W-1:0] half_o
);

  logic              int_en_q;
  logic              card_en_q;
  logic [1:0]        div_hi_q;
  logic [7:0]        div_lo_q;
  logic [HALF_W-1:0] half_q;
  logic [1:0]        hi_keep;
  logic              capture_div;
  logic              unused_wr_bits;

  // Upper field exists only in the even-divisor variant.
  generate
    if (DIV10_MODE) begin : g_hi_field
      assign hi_keep = wr_data[HI_LSB+1:HI_LSB];
    end else begin : g_no_hi_field
      assign hi_keep = 2'b00;
    end
  endgenerate

  assign unused_wr_bits = ^{wr_data[5:3], wr_data[BIT_STABLE], wr_data[HI_LSB+1:HI_LSB]};

  // Divisor is latched on the write that turns the internal clock on.
  assign capture_div = wr_en && wr_data[BIT_INT_EN] && !int_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q  <= 1'b0;
      card_en_q <= 1'b0;
      div_hi_q  <= '0;
      div_lo_q  <= '0;
      half_q    <= '0;
    end else begin
      if (wr_en) begin
        int_en_q  <= wr_data[BIT_INT_EN];
        card_en_q <= wr_data[BIT_CARD_EN];
        div_hi_q  <= hi_keep;
        div_lo_q  <= wr_data[LO_LSB+7:LO_LSB];
      end
      if (capture_div) begin
        half_q <= decode_half(DIV10_MODE, hi_keep, wr_data[LO_LSB+7:LO_LSB]);
      end
    end
  end

  assign int_en_o  = int_en_q;
  assign card_en_o = card_en_q;
  assign div_hi_o  = div_hi_q;
  assign div_lo_o  = div_lo_q;
  assign half_o    = half_q;

  // R10: while the clock keeps running the working divisor never moves
  assert_divisor_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en_q && $past(int_en_q)) |-> $stable(half_q));

endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_en_i,
  output logic stable_o
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;
  logic             settle_done;

  assign settle_done = int_en_i && !stable_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!int_en_i) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (settle_done) begin
      stable_q <= 1'b1;
    end else if (!stable_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stable_o = stable_q;

  // R3: the settle counter never runs past its terminal value
  assert_settle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en_i && !stable_q) |-> (cnt_q <= LAST));

endmodule

// File: rtl/sdclk_divcore.sv
module sdclk_divcore
  import sdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_en_i,
  input  logic              stable_i,
  input  logic              card_en_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              card_clk_o
);

  logic              pass_mode;
  logic [HALF_W-1:0] cnt_q;
  logic              tick;
  logic              co_q;
  logic              gate_q;
  logic [HALF_W-1:0] hi_run_q;

  assign pass_mode = (half_i == '0);

  // Half-period tick: the phase counter wraps after half_i base cycles.
  assign tick = int_en_i && !pass_mode && (cnt_q == half_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!int_en_i || pass_mode || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Divided output: a high phase starts only with the card enabled and
  // the clock stable, and always ends on a tick, so it is never cut short.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      co_q <= 1'b0;
    end else if (!int_en_i) begin
      co_q <= 1'b0;
    end else if (tick) begin
      co_q <= co_q ? 1'b0 : (card_en_i && stable_i);
    end
  end

  // Pass-through gate changes only while the base clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= card_en_i && int_en_i && stable_i && pass_mode;
    end
  end

  assign card_clk_o = pass_mode ? (clk & gate_q) : co_q;

  // Length of the current high phase, observed for the checks below.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
    end else if (co_q) begin
      hi_run_q <= hi_run_q + 1'b1;
    end else begin
      hi_run_q <= '0;
    end
  end

  // R8: with the card disabled a low output stays low
  assert_card_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_en_i && !co_q) |=> !co_q);

  // R8: no pulse starts before the internal clock is stable
  assert_wait_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stable_i && !co_q) |=> !co_q);

  // R9: a high phase that ends while the clock runs lasts exactly half_i cycles
  assert_full_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(co_q) && $past(int_en_i)) |-> (hi_run_q == half_i));

  // R5: the phase counter stays below the half period
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en_i && !pass_mode) |-> (cnt_q < half_i));

endmodule

// File: rtl/sdclk_divider_unit.sv
module sdclk_divider_unit
  import sdclk_pkg::*;
#(
  parameter bit DIV10_MODE    = 1'b0,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic        base_clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        card_clk
);

  logic              int_en;
  logic              card_en;
  logic [1:0]        div_hi;
  logic [7:0]        div_lo;
  logic [HALF_W-1:0] half;
  logic              stable_raw;
  logic              stable_vis;

  sdclk_ctrl_reg #(.DIV10_MODE(DIV10_MODE)) u_ctrl (
    .clk      (base_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .int_en_o (int_en),
    .card_en_o(card_en),
    .div_hi_o (div_hi),
    .div_lo_o (div_lo),
    .half_o   (half)
  );

  sdclk_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (base_clk),
    .rst_n   (rst_n),
    .int_en_i(int_en),
    .stable_o(stable_raw)
  );

  // Flag drops on the same edge that turns the internal clock off.
  assign stable_vis = stable_raw && int_en;

  sdclk_divcore u_core (
    .clk       (base_clk),
    .rst_n     (rst_n),
    .int_en_i  (int_en),
    .stable_i  (stable_vis),
    .card_en_i (card_en),
    .half_i    (half),
    .card_clk_o(card_clk)
  );

  always_comb begin
    rd_data                     = '0;
    rd_data[BIT_INT_EN]         = int_en;
    rd_data[BIT_STABLE]         = stable_vis;
    rd_data[BIT_CARD_EN]        = card_en;
    rd_data[HI_LSB+1:HI_LSB]    = div_hi;
    rd_data[LO_LSB+7:LO_LSB]    = div_lo;
  end

  // R3: turning the internal clock off clears the flag on that edge
  assert_stable_drop_R3: assert property (@(posedge base_clk) disable iff (!rst_n)
    (wr_en && !wr_data[BIT_INT_EN]) |=> !rd_data[BIT_STABLE]);

  // R2: the flag is never set on the edge that turns the clock on
  assert_no_early_stable_R2: assert property (@(posedge base_clk) disable iff (!rst_n)
    (wr_en && wr_data[BIT_INT_EN] && !rd_data[BIT_INT_EN]) |=> !rd_data[BIT_STABLE]);

endmodule

// File: tb/sdclk_divider_unit_bench.sv
module sdclk_divider_unit_bench;

  localparam time CLK_PERIOD = 10;
  localparam int  SETTLE     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en   [2];
  logic [15:0] wr_data [2];
  logic [15:0] rd_data [2];
  logic        cclk    [2];

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    mon_en   [2];
  int    tail_len [2];
  string cur_tag  [2];
  int    q0[$];
  int    q1[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdclk_divider_unit #(.DIV10_MODE(1'b0), .SETTLE_CYCLES(SETTLE)) u_sdclk_divider_unit (
    .base_clk(clk), .rst_n(rst_n), .wr_en(wr_en[0]), .wr_data(wr_data[0]),
    .rd_data(rd_data[0]), .card_clk(cclk[0])
  );

  sdclk_divider_unit #(.DIV10_MODE(1'b1), .SETTLE_CYCLES(SETTLE)) u_sdclk_divider_unit_w (
    .base_clk(clk), .rst_n(rst_n), .wr_en(wr_en[1]), .wr_data(wr_data[1]),
    .rd_data(rd_data[1]), .card_clk(cclk[1])
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void push_exp(input int w, input int v);
    if (w == 0) q0.push_back(v); else q1.push_back(v);
  endfunction

  function automatic int q_size(input int w);
    return (w == 0) ? q0.size() : q1.size();
  endfunction

  function automatic int pop_exp(input int w);
    if (w == 0) return q0.pop_front();
    return q1.pop_front();
  endfunction

  task automatic write_reg(input int w, input logic [15:0] d);
    @(negedge clk);
    wr_en[w]   = 1'b1;
    wr_data[w] = d;
    @(negedge clk);
    wr_en[w]   = 1'b0;
  endtask

  // Monitor: measures high and low phases, compares against the scoreboard.
  task automatic monitor(input int w);
    int run_hi;
    int run_lo;
    int exp;
    bit prev;
    bit seen_fall;
    run_hi = 0; run_lo = 0; prev = 0; seen_fall = 0;
    forever begin
      @(posedge clk); #1;
      if (!mon_en[w]) begin
        run_hi = 0; run_lo = 0; prev = 0; seen_fall = 0;
      end else begin
        if (cclk[w]) begin
          if (!prev && seen_fall)
            check(run_lo == tail_len[w], cur_tag[w], run_lo, tail_len[w]);
          run_hi++;
          run_lo = 0;
        end else begin
          if (prev) begin
            if (q_size(w) > 0) begin
              exp = pop_exp(w);
              check(run_hi == exp, cur_tag[w], run_hi, exp);
            end else begin
              check(run_hi == tail_len[w], "R9", run_hi, tail_len[w]);
            end
            seen_fall = 1;
          end
          run_lo++;
          run_hi = 0;
        end
        prev = cclk[w];
      end
    end
  endtask

  task automatic stop_card(input int w, input logic [15:0] word_on, input int half);
    while (q_size(w) > 0) @(negedge clk);
    do begin @(posedge clk); #1; end while (!cclk[w]);
    write_reg(w, word_on & 16'hFFFB);  // drop card enable mid-high (R9)
    repeat (2*half + 4) @(posedge clk);
    #1;
    check(cclk[w] == 1'b0, "R8", int'(cclk[w]), 0);
    mon_en[w] = 1'b0;
    write_reg(w, 16'h0000);
  endtask

  task automatic run_divided(input int w, input logic [7:0] lo, input logic [1:0] hi,
                             input int half, input int npulse, input string tag);
    logic [15:0] word;
    word = {lo, hi, 6'b000001};
    write_reg(w, word);
    repeat (SETTLE + 1) @(posedge clk);
    #1;
    check(rd_data[w][1] == 1'b1, "R3", int'(rd_data[w][1]), 1);
    tail_len[w] = half;
    cur_tag[w]  = tag;
    for (int i = 0; i < npulse; i++) push_exp(w, half);
    mon_en[w] = 1'b1;
    write_reg(w, word | 16'h0004);
    stop_card(w, word | 16'h0004, half);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int seen;
    for (int w = 0; w < 2; w++) begin
      wr_en[w] = 1'b0; wr_data[w] = '0; mon_en[w] = 1'b0;
      tail_len[w] = 0; cur_tag[w] = "";
    end
    fork
      monitor(0);
      monitor(1);
    join_none
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset value, both variants
    check(rd_data[0] == 16'h0000, "R1", int'(rd_data[0]), 0);
    check(rd_data[1] == 16'h0000, "R1", int'(rd_data[1]), 0);

    // R1/R2/R6 field readback with internal clock off
    write_reg(0, 16'hFFFE);
    write_reg(1, 16'hFFFE);
    #1;
    check(rd_data[0] == 16'hFF04, "R6", int'(rd_data[0]), 16'hFF04);
    check(rd_data[1] == 16'hFFC4, "R1", int'(rd_data[1]), 16'hFFC4);
    check(rd_data[1][1] == 1'b0, "R2", int'(rd_data[1][1]), 0);
    write_reg(0, 16'h0000);
    write_reg(1, 16'h0000);

    // R3 exact settle time
    write_reg(0, 16'h0101);
    repeat (SETTLE - 1) @(posedge clk);
    #1;
    check(rd_data[0][1] == 1'b0, "R3", int'(rd_data[0][1]), 0);
    @(posedge clk); #1;
    check(rd_data[0][1] == 1'b1, "R3", int'(rd_data[0][1]), 1);
    write_reg(0, 16'h0100);
    #1;
    check(rd_data[0][1] == 1'b0, "R2", int'(rd_data[0][1]), 0);

    // R4 pass-through
    write_reg(0, 16'h0001);
    repeat (SETTLE + 1) @(posedge clk);
    write_reg(0, 16'h0005);
    repeat (2) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      check(cclk[0] == 1'b1, "R4", int'(cclk[0]), 1);
      @(negedge clk); #2;
      check(cclk[0] == 1'b0, "R4", int'(cclk[0]), 0);
    end
    write_reg(0, 16'h0001);
    repeat (2) @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      check(cclk[0] == 1'b0, "R8", int'(cclk[0]), 0);
    end
    write_reg(0, 16'h0000);

    // R8 no card clock before the stable flag, then it starts
    write_reg(0, {8'd2, 2'b00, 6'b000101});
    seen = 0;
    for (int i = 0; i < SETTLE; i++) begin
      @(posedge clk); #1;
      if (cclk[0]) seen++;
    end
    check(seen == 0, "R8", seen, 0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      if (cclk[0]) seen++;
    end
    check(seen == 4 || seen == 5 || seen == 6, "R8", seen, 5);
    write_reg(0, 16'h0000);

    // R5 power-of-two ratios, including the largest
    run_divided(0, 8'd1,   2'b00, 1,   4, "R5");
    run_divided(0, 8'd8,   2'b00, 8,   3, "R5");
    run_divided(0, 8'd128, 2'b00, 128, 2, "R5");

    // R6 multi-bit codes round down; upper field has no effect
    run_divided(0, 8'd6,   2'b00, 4,   3, "R6");
    run_divided(0, 8'hFF,  2'b11, 128, 2, "R6");

    // R7 even-divisor ratios
    run_divided(1, 8'd3,   2'b00, 3,    3, "R7");
    run_divided(1, 8'h05,  2'b01, 261,  2, "R7");
    run_divided(1, 8'hFF,  2'b11, 1023, 2, "R7");

    // R10 divisor change while running is deferred to the next restart
    write_reg(0, {8'd4, 2'b00, 6'b000001});
    repeat (SETTLE + 1) @(posedge clk);
    tail_len[0] = 4;
    cur_tag[0]  = "R10";
    for (int i = 0; i < 6; i++) push_exp(0, 4);
    mon_en[0] = 1'b1;
    write_reg(0, {8'd4, 2'b00, 6'b000101});
    write_reg(0, {8'd16, 2'b00, 6'b000101});
    #1;
    check(rd_data[0][15:8] == 8'd16, "R10", int'(rd_data[0][15:8]), 16);
    stop_card(0, {8'd16, 2'b00, 6'b000101}, 4);
    run_divided(0, 8'd16, 2'b00, 16, 3, "R10");

    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule